// File: doc/BRIEF.md
# Sector Load and Program Controller

This block gathers single-word write strobes into a one-sector staging buffer and then commits that buffer to an internal memory array as a timed, self-contained program cycle. The first accepted write opens a load window and fixes the target sector. Further writes to the same sector may arrive in any order. Each one restarts an inactivity timer. When the timer runs out, the window closes.

Closing the window starts the program cycle, and the busy output is held high for its whole fixed length. The controller first erases every word of the target sector to all-ones. It then writes only the words that were loaded. The whole sector is therefore replaced: any word that was not loaded reads back as all-ones.

Write strobes are filtered before they are used. A strobe counts only while the select and write-strobe inputs are both low. Strobes that are too short are discarded, and so are strobes made while the output enable is low. A read port gives combinational access to the array.

Top module: `sector_prog_ctrl`

## Requirements
- R1: After reset, busy is 0 and every array word reads 16'hFFFF.
- R2: Address bits [ADDR_W-1:7] select the sector and bits [6:0] select the word within it. Words of a window may be loaded in any order.
- R3: Every accepted write restarts a LOAD_CYCLES inactivity timer. The window stays open while strobes keep arriving within that time. Busy rises a few cycles after LOAD_CYCLES have passed with no strobe.
- R4: Busy stays high for exactly PROG_CYCLES cycles. During the first 128 of them, every word of the target sector is written with 16'hFFFF (erase pass), before any loaded data is written.
- R5: After a program cycle, a sector word that was not loaded in that window reads 16'hFFFF, even if it held data from an earlier program cycle.
- R6: The word address is captured in the first cycle in which sel_n and wstb_n are both low. The data is captured in the first cycle in which either of them is high again.
- R7: A strobe during which out_en_n is sampled low in any cycle is discarded. If it would have been the first write, no window opens and busy stays 0.
- R8: A strobe lasting fewer than MIN_PULSE clock cycles is discarded and opens no window.
- R9: Once the first write of a window has fixed the sector, writes addressed to any other sector are ignored.
- R10: Writes made while busy is high change neither the array nor the buffer, and open no new window.
- R11: When the same word is written twice in one window, the later data is programmed.
- R12: A program cycle leaves the words of every other sector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low device select |
| wstb_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable; low inhibits writes |
| addr | input | ADDR_W | Write address: sector and word |
| wdata | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Array word at rd_addr |
| busy | output | 1 | High for the whole program cycle |

## Verification
The hardest situation to reach is a word that was programmed in one cycle being erased by a later cycle that did not load it. The bench programs a sector once, programs a different word of the same sector in a second window, and reads the first word back as all-ones. Window extension is the other delicate case: the bench places a second strobe a few cycles before the timeout, then checks that busy is still low after the point where the first write alone would have closed the window. Strobes that move their address mid-pulse or change data before release show which edge captures each field.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int DATA_W_DEF    = 16;
    localparam int WORD_BITS_DEF = 7;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_ERASE,
        SEQ_PROG,
        SEQ_HOLD
    } seq_state_e;
endpackage

// File: rtl/spc_strobe_filter.sv
module spc_strobe_filter #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              strobe_act,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int LEN_W = $clog2(MIN_PULSE + 1);

    typedef struct packed {
        logic              act;
        logic              oe_bad;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] cap_addr;
        logic              vld;
        logic [ADDR_W-1:0] out_addr;
        logic [DATA_W-1:0] out_data;
    } flt_t;

    flt_t q, d;
    logic act_now;

    always_comb begin
        act_now = !sel_n && !wstb_n;
        d       = q;
        d.vld   = 1'b0;
        d.act   = act_now;
        if (act_now && !q.act) begin
            // strobe start: the later of the two falling inputs
            d.cap_addr = addr;
            d.len      = LEN_W'(1);
            d.oe_bad   = !out_en_n;
        end else if (act_now) begin
            if (q.len < LEN_W'(MIN_PULSE)) begin
                d.len = q.len + LEN_W'(1);
            end
            d.oe_bad = q.oe_bad || !out_en_n;
        end else if (q.act) begin
            // strobe end: first rising input, data taken here
            if ((q.len >= LEN_W'(MIN_PULSE)) && !q.oe_bad && out_en_n) begin
                d.vld      = 1'b1;
                d.out_addr = q.cap_addr;
                d.out_data = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign strobe_act = q.act;
    assign wr_vld     = q.vld;
    assign wr_addr    = q.out_addr;
    assign wr_data    = q.out_data;
endmodule

// File: rtl/spc_sector_buffer.sv
module spc_sector_buffer #(
    parameter int DATA_W    = 16,
    parameter int WORD_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 we,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [WORD_BITS-1:0] rd_word,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid
);
    localparam int WORDS = 1 << WORD_BITS;

    typedef struct packed {
        logic [WORDS-1:0]             valid;
        logic [WORDS-1:0][DATA_W-1:0] data;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.valid = '0;
        end
        if (we) begin
            d.valid[wr_word] = 1'b1;
            d.data[wr_word]  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data  = q.data[rd_word];
    assign rd_valid = q.valid[rd_word];
endmodule

// File: rtl/spc_sequencer.sv
module spc_sequencer
    import spc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int WORD_BITS   = 7,
    parameter int LOAD_CYCLES = 15000,
    parameter int PROG_CYCLES = 1000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strobe_act,
    input  logic                        wr_vld,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic                        buf_clr,
    output logic                        buf_we,
    output logic [WORD_BITS-1:0]        buf_word,
    output logic [DATA_W-1:0]           buf_wdata,
    output logic [WORD_BITS-1:0]        buf_rd_word,
    input  logic [DATA_W-1:0]           buf_rd_data,
    input  logic                        buf_rd_valid,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_waddr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic [ADDR_W-WORD_BITS-1:0] sector,
    output logic                        busy
);
    localparam int WORDS    = 1 << WORD_BITS;
    localparam int SEC_W    = ADDR_W - WORD_BITS;
    localparam int PROG_EFF = (PROG_CYCLES > 2 * WORDS) ? PROG_CYCLES : 2 * WORDS + 1;
    localparam int TMR_W    = $clog2(LOAD_CYCLES + 1);
    localparam int CYC_W    = $clog2(PROG_EFF + 1);

    typedef struct packed {
        seq_state_e           state;
        logic [SEC_W-1:0]     sector;
        logic [WORD_BITS-1:0] idx;
        logic [TMR_W-1:0]     timer;
        logic [CYC_W-1:0]     cyc;
    } seq_t;

    seq_t q, d;
    logic sec_match;

    always_comb begin
        d         = q;
        sec_match = (wr_addr[ADDR_W-1:WORD_BITS] == q.sector);
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        buf_word  = wr_addr[WORD_BITS-1:0];
        buf_wdata = wr_data;
        mem_we    = 1'b0;
        mem_waddr = {q.sector, q.idx};
        mem_wdata = '1;
        unique case (q.state)
            SEQ_IDLE: begin
                if (wr_vld) begin
                    d.sector = wr_addr[ADDR_W-1:WORD_BITS];
                    d.timer  = '0;
                    d.state  = SEQ_LOAD;
                    buf_clr  = 1'b1;
                    buf_we   = 1'b1;
                end
            end
            SEQ_LOAD: begin
                if (wr_vld && sec_match) begin
                    buf_we  = 1'b1;
                    d.timer = '0;
                end else if (!strobe_act) begin
                    if (q.timer >= TMR_W'(LOAD_CYCLES - 1)) begin
                        d.state = SEQ_ERASE;
                        d.idx   = '0;
                        d.cyc   = '0;
                    end else begin
                        d.timer = q.timer + TMR_W'(1);
                    end
                end
            end
            SEQ_ERASE: begin
                mem_we = 1'b1;
                d.cyc  = q.cyc + CYC_W'(1);
                d.idx  = q.idx + WORD_BITS'(1);
                if (&q.idx) begin
                    d.state = SEQ_PROG;
                end
            end
            SEQ_PROG: begin
                mem_we    = buf_rd_valid;
                mem_wdata = buf_rd_data;
                d.cyc     = q.cyc + CYC_W'(1);
                d.idx     = q.idx + WORD_BITS'(1);
                if (&q.idx) begin
                    d.state = SEQ_HOLD;
                end
            end
            SEQ_HOLD: begin
                if (q.cyc >= CYC_W'(PROG_EFF - 1)) begin
                    d.state = SEQ_IDLE;
                end else begin
                    d.cyc = q.cyc + CYC_W'(1);
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign buf_rd_word = q.idx;
    assign sector      = q.sector;
    assign busy        = (q.state == SEQ_ERASE) || (q.state == SEQ_PROG) ||
                         (q.state == SEQ_HOLD);
endmodule

// File: rtl/spc_array.sv
module spc_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '1;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl #(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = spc_pkg::DATA_W_DEF,
    parameter int WORD_BITS   = spc_pkg::WORD_BITS_DEF,
    parameter int LOAD_CYCLES = 15000,
    parameter int PROG_CYCLES = 1000000,
    parameter int MIN_PULSE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int SEC_W = ADDR_W - WORD_BITS;

    logic                 strobe_act;
    logic                 wr_vld;
    logic [ADDR_W-1:0]    wr_addr;
    logic [DATA_W-1:0]    wr_data;
    logic                 buf_clr;
    logic                 buf_we;
    logic [WORD_BITS-1:0] buf_word;
    logic [DATA_W-1:0]    buf_wdata;
    logic [WORD_BITS-1:0] buf_rd_word;
    logic [DATA_W-1:0]    buf_rd_data;
    logic                 buf_rd_valid;
    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [DATA_W-1:0]    mem_wdata;
    logic [SEC_W-1:0]     sector;

    spc_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_filter (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .out_en_n(out_en_n),
        .addr(addr), .wdata(wdata), .strobe_act(strobe_act), .wr_vld(wr_vld),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    spc_sector_buffer #(.DATA_W(DATA_W), .WORD_BITS(WORD_BITS)) u_buffer (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we), .wr_word(buf_word),
        .wr_data(buf_wdata), .rd_word(buf_rd_word), .rd_data(buf_rd_data),
        .rd_valid(buf_rd_valid)
    );

    spc_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BITS(WORD_BITS),
        .LOAD_CYCLES(LOAD_CYCLES), .PROG_CYCLES(PROG_CYCLES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe_act(strobe_act), .wr_vld(wr_vld),
        .wr_addr(wr_addr), .wr_data(wr_data), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_word(buf_word), .buf_wdata(buf_wdata), .buf_rd_word(buf_rd_word),
        .buf_rd_data(buf_rd_data), .buf_rd_valid(buf_rd_valid), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .sector(sector), .busy(busy)
    );

    spc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int DATA_W      = 16,
    parameter int SEC_W       = 3,
    parameter int WORDS       = 128,
    parameter int PROG_CYCLES = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [SEC_W-1:0]  sector
);
    localparam int PROG_EFF = (PROG_CYCLES > 2 * WORDS) ? PROG_CYCLES : 2 * WORDS + 1;

    int busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt_q <= 0;
        end else if (busy) begin
            busy_cnt_q <= busy_cnt_q + 1;
        end else begin
            busy_cnt_q <= 0;
        end
    end

    // R10: the array is only written during a program cycle
    p_write_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R4: the erase pass fills the sector with ones before any data
    p_erase_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt_q < WORDS) |-> (mem_we && mem_wdata == '1));

    // R4: busy lasts exactly the program cycle length
    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt_q == PROG_EFF));

    // R9: the target sector does not move during a program cycle
    p_sector_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sector));
endmodule

bind sector_prog_ctrl spc_checker #(
    .DATA_W(DATA_W), .SEC_W(ADDR_W - WORD_BITS), .WORDS(1 << WORD_BITS),
    .PROG_CYCLES(PROG_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .sector(sector)
);

// File: tb/sector_prog_ctrl_bench.sv
module sector_prog_ctrl_bench;
    localparam int AW   = 10;
    localparam int LOAD = 40;
    localparam int PROG = 400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wstb_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sector_prog_ctrl #(
        .ADDR_W(AW), .LOAD_CYCLES(LOAD), .PROG_CYCLES(PROG), .MIN_PULSE(2)
    ) u_sector_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wstb_n(wstb_n), .out_en_n(out_en_n),
        .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] wa(input int sec, input int word);
        return AW'(sec * 128 + word);
    endfunction

    task automatic rd_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(rd_data === exp, tag, int'(rd_data), int'(exp));
    endtask

    // generic strobe: address/data may switch halfway through
    task automatic strobe(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                          input logic [15:0] d0, input logic [15:0] d1,
                          input int len, input bit oe_low);
        @(negedge clk);
        addr = a0; wdata = d0; sel_n = 1'b0; wstb_n = 1'b0; out_en_n = oe_low;
        out_en_n = !oe_low;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == len / 2) begin
                addr = a1; wdata = d1;
            end
        end
        wstb_n = 1'b1; sel_n = 1'b1; out_en_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        strobe(a, a, d, d, 4, 1'b0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for a whole program cycle, optionally issuing a write in it
    task automatic run_prog(input string tag, input bit poke, input logic [AW-1:0] pa);
        int t_rise = 0;
        int t_fall = 0;
        int guard = 0;
        while (!busy && guard < LOAD + 20) begin
            @(negedge clk);
            guard++;
        end
        check(busy === 1'b1, {tag, " R3 window closes"}, int'(busy), 1);
        t_rise = cyc;
        if (poke) begin
            idle(10);
            wr(pa, 16'h9999);
        end
        guard = 0;
        while (busy && guard < PROG + 20) begin
            @(negedge clk);
            guard++;
        end
        t_fall = cyc;
        check((t_fall - t_rise) == PROG, {tag, " R4 busy length"}, t_fall - t_rise, PROG);
    endtask

    task automatic t_reset();
        check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
        rd_chk(wa(0, 0), 16'hFFFF, "R1 reset word 0");
        rd_chk(wa(5, 77), 16'hFFFF, "R1 reset sector 5");
        rd_chk(wa(7, 127), 16'hFFFF, "R1 reset last word");
    endtask

    task automatic t_main_load();
        wr(wa(2, 5), 16'h1111);
        wr(wa(2, 0), 16'h2222);
        wr(wa(2, 127), 16'h3333);
        wr(wa(2, 5), 16'h4444);
        wr(wa(3, 4), 16'h5555);
        strobe(wa(2, 9), wa(2, 9), 16'h6666, 16'h6666, 4, 1'b1);
        strobe(wa(2, 10), wa(2, 10), 16'h7070, 16'h7070, 1, 1'b0);
        strobe(wa(2, 20), wa(2, 21), 16'h7777, 16'h8888, 4, 1'b0);
        idle(LOAD - 4);
        check(busy === 1'b0, "R3 still open before timeout", int'(busy), 0);
        run_prog("main", 1'b1, wa(2, 30));
        idle(LOAD + 20);
        check(busy === 1'b0, "R10 no window from busy write", int'(busy), 0);
        rd_chk(wa(2, 0), 16'h2222, "R2 word 0");
        rd_chk(wa(2, 127), 16'h3333, "R2 word 127");
        rd_chk(wa(2, 5), 16'h4444, "R11 rewrite last wins");
        rd_chk(wa(2, 20), 16'h8888, "R6 start addr end data");
        rd_chk(wa(2, 21), 16'hFFFF, "R6 late addr unused");
        rd_chk(wa(2, 9), 16'hFFFF, "R7 oe-low strobe ignored");
        rd_chk(wa(2, 10), 16'hFFFF, "R8 short strobe ignored");
        rd_chk(wa(3, 4), 16'hFFFF, "R9 other sector ignored");
        rd_chk(wa(2, 30), 16'hFFFF, "R10 busy write ignored");
        rd_chk(wa(1, 5), 16'hFFFF, "R12 neighbour sector");
    endtask

    task automatic t_extend();
        wr(wa(0, 3), 16'hAAAA);
        idle(LOAD - 6);
        wr(wa(0, 4), 16'hBBBB);
        idle(LOAD - 6);
        check(busy === 1'b0, "R3 window extended", int'(busy), 0);
        run_prog("extend", 1'b0, '0);
        rd_chk(wa(0, 3), 16'hAAAA, "R3 first word kept");
        rd_chk(wa(0, 4), 16'hBBBB, "R3 second word kept");
    endtask

    task automatic t_reprogram();
        wr(wa(2, 1), 16'hCCCC);
        run_prog("reprog", 1'b0, '0);
        rd_chk(wa(2, 1), 16'hCCCC, "R5 new word");
        rd_chk(wa(2, 5), 16'hFFFF, "R5 old word erased");
        rd_chk(wa(2, 127), 16'hFFFF, "R5 old last word erased");
        rd_chk(wa(0, 3), 16'hAAAA, "R12 other sector intact");
    endtask

    task automatic t_inhibit_only();
        strobe(wa(4, 1), wa(4, 1), 16'h1234, 16'h1234, 4, 1'b1);
        idle(LOAD + 30);
        check(busy === 1'b0, "R7 no window from inhibited write", int'(busy), 0);
        strobe(wa(4, 2), wa(4, 2), 16'h4321, 16'h4321, 1, 1'b0);
        idle(LOAD + 30);
        check(busy === 1'b0, "R8 no window from short strobe", int'(busy), 0);
        rd_chk(wa(4, 1), 16'hFFFF, "R7 word untouched");
        rd_chk(wa(4, 2), 16'hFFFF, "R8 word untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_main_load();
        t_extend();
        t_reprogram();
        t_inhibit_only();
        done = 1'b1;
        summary();
        $finish;
    end
endmodule